// File: doc/BRIEF.md
# CRC-Checked Register Access Frame Controller

This block is the slave-side transaction engine of a byte-serial register bus. A UART receiver hands it one byte at a time, and it marks the byte that opens a frame as the sync byte. After the sync byte, the block collects a header byte and a starting register address. Write frames then carry one, two, four or eight data bytes. Every frame ends with a CRC-8 byte.

When the CRC matches and the frame is addressed to this device (or to all devices), the block acts on the frame:
- It runs the register accesses one per cycle on a simple register-bank port.
- It clears the watchdog with a one-cycle pulse.
- It places the reply bytes in a small queue. A UART transmitter drains the queue through a valid/ready handshake.

A frame that fails the CRC, or that targets another device, leaves no trace: no register is touched, no reply is sent and the watchdog is not cleared. An abort strobe from the receiver drops both a partly received frame and any reply that is still queued.

Top module: `rfc_frame_ctrl`

## Requirements
- R1: A frame opens with a byte presented with `rx_sync` high. Its content is not used. Then follow the header byte, the starting register address, the data bytes (write frames only) and the CRC byte. Bytes without `rx_sync` that arrive while no frame is open are ignored. After reset, `tx_valid`, `wdog_clr`, `reg_wr_en` and `reg_rd_en` are low.
- R2: Header byte fields:
  - Bit 7 selects read (1) or write (0).
  - Bit 6 marks a broadcast.
  - Bits 5:4 give the burst length: 00 is 1 byte, 01 is 2, 10 is 4 and 11 is 8.
  - Bits 3:0 hold the target device address.
  A frame is addressed to this device when bits 3:0 equal `dev_id` or when bit 6 is set.
- R3: The CRC is CRC-8 with polynomial 0x07, initial value 0xFF, bits taken most significant first and no final inversion. It runs over the header, the address and the data bytes, never the sync byte. A frame is accepted only when its last byte equals this CRC.
- R4: A rejected frame (CRC mismatch or not addressed) writes no register, queues no reply byte and gives no watchdog pulse.
- R5: For an accepted write, data byte i is written to register (address + i) modulo 256, one per cycle. The first write strobe is high in the cycle right after the CRC byte is sampled.
- R6: For an accepted read, registers address + i (modulo 256) are read one per cycle. Their values are queued as reply bytes in ascending order.
- R7: Every reply ends with one acknowledge byte equal to `flag_val`. A write reply is the acknowledge byte alone. A read reply is the data bytes followed by the acknowledge byte.
- R8: A broadcast write is applied to the registers, but no reply byte is queued.
- R9: `wdog_clr` is a single-cycle pulse, high in the cycle right after an accepted CRC byte is sampled.
- R10: `frame_abort` returns the controller to idle. It drops the partial frame, and the bytes that follow are ignored until the next sync byte. It empties the reply queue, so `tx_valid` is low in the next cycle.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_byte` is held unchanged. A byte leaves the queue on each cycle in which both are high.
- R12: A sync byte that arrives during reception restarts the frame and discards the bytes received so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| rx_sync | input | 1 | The valid byte is a frame-opening sync byte |
| frame_abort | input | 1 | Drop the current frame and the queued reply |
| dev_id | input | 4 | This device's address |
| flag_val | input | 8 | Current flag register value, used as acknowledge byte |
| reg_rdata | input | 8 | Read data from the register bank, same cycle as reg_rd_en |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| tx_byte | output | 8 | Reply byte at the queue head |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmitter takes tx_byte |
| wdog_clr | output | 1 | Watchdog clear pulse |

## Verification
The bench samples the CRC byte's outcome in the half cycle after the rising edge that takes that byte in:
- `wdog_clr`, `reg_wr_en` and the first register address are already due there.
- The remaining register accesses follow on the next burst-length edges.
- The acknowledge byte enters the queue one edge after the last access.

Reply bytes are gathered as they are handed over, and memory contents are compared only after a fixed settling wait well beyond the nine-cycle execution window. Held-output and abort checks look at the port one half cycle after the edge that applies the stimulus.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int ID_W      = 4;
  localparam int LEN_W     = 2;
  localparam int MAX_BURST = 1 << ((1 << LEN_W) - 1);
  localparam int CNT_W     = $clog2(MAX_BURST);
  localparam int HB_READ   = 7;
  localparam int HB_BCAST  = 6;
  localparam int HB_LEN    = 4;
  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam logic [7:0] CRC_INIT = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_DATA, ST_CRC, ST_EXEC, ST_ACK
  } rfc_state_e;

  // One byte through the CRC-8 register, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

  // Burst length from the 2-bit header code.
  function automatic logic [CNT_W:0] burst_len(input logic [LEN_W-1:0] code);
    return (CNT_W+1)'(1) << code;
  endfunction
endpackage

// File: rtl/rfc_crc_acc.sv
module rfc_crc_acc
  import rfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= CRC_INIT;
    else if (clr) crc <= CRC_INIT;
    else if (upd) crc <= crc8_step(crc, din);
  end
endmodule

// File: rtl/rfc_frame_fsm.sv
module rfc_frame_fsm
  import rfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      rx_byte,
  input  logic            rx_valid,
  input  logic            rx_sync,
  input  logic            abort,
  input  logic [ID_W-1:0] dev_id,
  input  logic [7:0]      flag_val,
  input  logic [7:0]      reg_rdata,
  output logic            reg_wr_en,
  output logic            reg_rd_en,
  output logic [7:0]      reg_addr,
  output logic [7:0]      reg_wdata,
  output logic            push_valid,
  output logic [7:0]      push_data,
  output logic            frame_accept,
  output logic            wdog_clr
);
  rfc_state_e     state_q;
  logic [7:0]     hdr_q;
  logic [7:0]     base_q;
  logic [7:0]     buf_q [MAX_BURST];
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]     crc_val;

  // Named internal events
  logic busy, rx_data, sync_evt, crc_clr, crc_upd, cnt_last;
  logic hdr_rd, hdr_bc, addressed;

  assign busy      = (state_q == ST_EXEC) || (state_q == ST_ACK);
  assign rx_data   = rx_valid && !rx_sync && !abort && !busy;
  assign sync_evt  = rx_valid && rx_sync && !abort && !busy;
  assign hdr_rd    = hdr_q[HB_READ];
  assign hdr_bc    = hdr_q[HB_BCAST];
  assign addressed = hdr_bc || (hdr_q[ID_W-1:0] == dev_id);
  assign cnt_last  = ({1'b0, cnt_q} == burst_len(hdr_q[HB_LEN +: LEN_W]) - 1'b1);
  assign crc_clr   = sync_evt;
  assign crc_upd   = rx_data && ((state_q == ST_DEV) || (state_q == ST_REG) ||
                                 (state_q == ST_DATA));
  assign frame_accept = rx_data && (state_q == ST_CRC) && (rx_byte == crc_val) && addressed;

  rfc_crc_acc u_crc (
    .clk (clk), .rst_n (rst_n), .clr (crc_clr), .upd (crc_upd),
    .din (rx_byte), .crc (crc_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else if (abort) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (state_q == ST_EXEC) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_last) begin
        state_q <= ST_ACK;
        cnt_q   <= '0;
      end
    end else if (state_q == ST_ACK) begin
      state_q <= ST_IDLE;
    end else if (sync_evt) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
    end else if (rx_data) begin
      case (state_q)
        ST_DEV: begin
          hdr_q   <= rx_byte;
          state_q <= ST_REG;
        end
        ST_REG: begin
          base_q  <= rx_byte;
          cnt_q   <= '0;
          state_q <= hdr_rd ? ST_CRC : ST_DATA;
        end
        ST_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_last) begin
            cnt_q   <= '0;
            state_q <= ST_CRC;
          end
        end
        ST_CRC:  state_q <= frame_accept ? ST_EXEC : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Data buffer, one slot per burst position
  for (genvar g = 0; g < MAX_BURST; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_q[g] <= '0;
      else if (rx_data && (state_q == ST_DATA) && (cnt_q == CNT_W'(g))) buf_q[g] <= rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdog_clr <= 1'b0;
    else        wdog_clr <= frame_accept;
  end

  assign reg_wr_en  = (state_q == ST_EXEC) && !hdr_rd;
  assign reg_rd_en  = (state_q == ST_EXEC) && hdr_rd && !hdr_bc;
  assign reg_addr   = base_q + 8'(cnt_q);
  assign reg_wdata  = buf_q[cnt_q];
  assign push_valid = !hdr_bc && (reg_rd_en || (state_q == ST_ACK));
  assign push_data  = (state_q == ST_EXEC) ? reg_rdata : flag_val;

  a_r5_wr_rd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));
  a_r6_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr_en || reg_rd_en) && $past(reg_wr_en || reg_rd_en)) |->
      (reg_addr == $past(reg_addr) + 8'd1));
  a_r9_wdog_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_clr |=> !wdog_clr);
  a_r10_abort_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !(reg_wr_en || reg_rd_en || push_valid));
  a_r4_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_IDLE && state_q == ST_IDLE) |-> !(reg_wr_en || push_valid));
endmodule

// File: rtl/rfc_resp_fifo.sv
module rfc_resp_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  logic [7:0] push_data,
  output logic [7:0] tx_byte,
  output logic       tx_valid,
  input  logic       tx_ready
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]  mem_q [DEPTH];
  logic [AW:0] wr_q, rd_q;
  logic        full, do_push, do_pop;

  assign full     = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign tx_valid = (wr_q != rd_q);
  assign tx_byte  = mem_q[rd_q[AW-1:0]];
  assign do_push  = push && !full && !flush;
  assign do_pop   = tx_valid && tx_ready && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (do_push && (wr_q[AW-1:0] == AW'(g))) mem_q[g] <= push_data;
    end
  end

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(tx_byte)));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !tx_valid);
endmodule

// File: rtl/rfc_frame_ctrl.sv
module rfc_frame_ctrl
  import rfc_pkg::*;
#(
  parameter int RESP_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      rx_byte,
  input  logic            rx_valid,
  input  logic            rx_sync,
  input  logic            frame_abort,
  input  logic [ID_W-1:0] dev_id,
  input  logic [7:0]      flag_val,
  input  logic [7:0]      reg_rdata,
  output logic            reg_wr_en,
  output logic            reg_rd_en,
  output logic [7:0]      reg_addr,
  output logic [7:0]      reg_wdata,
  output logic [7:0]      tx_byte,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            wdog_clr
);
  localparam int MIN_DEPTH = MAX_BURST + 1;

  logic       push_valid;
  logic [7:0] push_data;
  logic       frame_accept;

  initial begin
    if (RESP_DEPTH < MIN_DEPTH || (RESP_DEPTH & (RESP_DEPTH - 1)) != 0)
      $error("RESP_DEPTH must be a power of two of at least %0d", MIN_DEPTH);
  end

  rfc_frame_fsm u_fsm (
    .clk (clk), .rst_n (rst_n),
    .rx_byte (rx_byte), .rx_valid (rx_valid), .rx_sync (rx_sync),
    .abort (frame_abort), .dev_id (dev_id), .flag_val (flag_val),
    .reg_rdata (reg_rdata), .reg_wr_en (reg_wr_en), .reg_rd_en (reg_rd_en),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .push_valid (push_valid), .push_data (push_data),
    .frame_accept (frame_accept), .wdog_clr (wdog_clr)
  );

  rfc_resp_fifo #(.DEPTH (RESP_DEPTH)) u_fifo (
    .clk (clk), .rst_n (rst_n), .flush (frame_abort),
    .push (push_valid), .push_data (push_data),
    .tx_byte (tx_byte), .tx_valid (tx_valid), .tx_ready (tx_ready)
  );

  a_r9_accept_clears_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |=> wdog_clr);
  a_r7_write_reply_single: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && push_valid) |-> 1'b0);
endmodule

// File: tb/test_rfc_frame_ctrl.sv
module test_rfc_frame_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_valid = 1'b0, rx_sync = 1'b0, frame_abort = 1'b0;
  logic [3:0] dev_id = 4'h5;
  logic [7:0] flag_val = 8'h3C;
  logic [7:0] reg_rdata;
  logic reg_wr_en, reg_rd_en, tx_valid, wdog_clr;
  logic tx_ready = 1'b1;
  logic [7:0] reg_addr, reg_wdata, tx_byte;

  int checks = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] rq [32];
  int rn = 0;
  int wd_cnt = 0;
  logic [7:0] wd [8];
  bit done = 0;

  always #10 clk = ~clk;

  rfc_frame_ctrl i_rfc_frame_ctrl (
    .clk (clk), .rst_n (rst_n), .rx_byte (rx_byte), .rx_valid (rx_valid),
    .rx_sync (rx_sync), .frame_abort (frame_abort), .dev_id (dev_id),
    .flag_val (flag_val), .reg_rdata (reg_rdata), .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .tx_byte (tx_byte), .tx_valid (tx_valid), .tx_ready (tx_ready),
    .wdog_clr (wdog_clr)
  );

  assign reg_rdata = mem[reg_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);

  always @(posedge clk) begin
    if (reg_wr_en) mem[reg_addr] <= reg_wdata;
    if (tx_valid && tx_ready && rn < 32) begin
      rq[rn] <= tx_byte;
      rn <= rn + 1;
    end
    if (wdog_clr) wd_cnt <= wd_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench-side CRC: bit-serial shift register with feedback
  function automatic logic [7:0] tb_crc(input logic [7:0] c, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = c[7] ^ b[k];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic logic [7:0] mk_hdr(input bit rd, input bit bc, input logic [1:0] code, input logic [3:0] id);
    return {rd, bc, code, id};
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit sync);
    @(negedge clk);
    rx_byte = b; rx_valid = 1'b1; rx_sync = sync;
    @(negedge clk);
    rx_valid = 1'b0; rx_sync = 1'b0;
  endtask

  // Sends a full frame; returns in the half cycle after the CRC byte is sampled.
  task automatic send_frame(input logic [7:0] hdr, input logic [7:0] ra, input int n,
                            input logic [7:0] crc_flip, input bit sync_in_crc);
    logic [7:0] c;
    c = 8'hFF;
    if (sync_in_crc) c = tb_crc(c, 8'h55);
    c = tb_crc(c, hdr);
    c = tb_crc(c, ra);
    for (int i = 0; i < n; i++) c = tb_crc(c, wd[i]);
    send_byte(8'h55, 1'b1);
    send_byte(hdr, 1'b0);
    send_byte(ra, 1'b0);
    for (int i = 0; i < n; i++) send_byte(wd[i], 1'b0);
    @(negedge clk);
    rx_byte = c ^ crc_flip; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx_valid == 0, "R1 reset tx_valid", 32'(tx_valid), 0);
    chk(wdog_clr == 0, "R1 reset wdog_clr", 32'(wdog_clr), 0);
    chk(!(reg_wr_en || reg_rd_en), "R1 reset reg strobes", 32'({reg_wr_en, reg_rd_en}), 0);
  endtask

  task automatic t_single_write();
    int w0;
    w0 = wd_cnt; rn = 0;
    wd[0] = 8'h5A;
    send_frame(mk_hdr(0, 0, 2'b00, 4'h5), 8'h10, 1, 8'h00, 0);
    chk(wdog_clr == 1, "R9 wdog pulse timing", 32'(wdog_clr), 1);
    chk(reg_wr_en == 1 && reg_addr == 8'h10, "R5 first write strobe timing",
        32'({reg_wr_en, reg_addr}), 32'({1'b1, 8'h10}));
    settle();
    chk(mem[8'h10] == 8'h5A, "R5 single write data", 32'(mem[8'h10]), 32'h5A);
    chk(rn == 1 && rq[0] == 8'h3C, "R7 write reply is ack only",
        32'({rn[7:0], rq[0]}), 32'({8'd1, 8'h3C}));
    chk(wd_cnt == w0 + 1, "R9 single pulse per frame", 32'(wd_cnt - w0), 1);
  endtask

  task automatic t_burst_write4();
    logic [7:0] keep;
    keep = mem[8'h24]; rn = 0;
    for (int i = 0; i < 4; i++) wd[i] = 8'(8'hA0 + i * 8'h11);
    send_frame(mk_hdr(0, 0, 2'b10, 4'h5), 8'h20, 4, 8'h00, 0);
    settle();
    for (int i = 0; i < 4; i++)
      chk(mem[8'h20 + i] == wd[i], "R2 R5 burst of four written", 32'(mem[8'h20 + i]), 32'(wd[i]));
    chk(mem[8'h24] == keep, "R2 burst stops after four", 32'(mem[8'h24]), 32'(keep));
    chk(rn == 1, "R7 burst write reply length", 32'(rn), 1);
  endtask

  task automatic t_read_single();
    rn = 0; flag_val = 8'hC3;
    send_frame(mk_hdr(1, 0, 2'b00, 4'h5), 8'h10, 0, 8'h00, 0);
    settle();
    chk(rn == 2, "R6 single read reply length", 32'(rn), 2);
    chk(rq[0] == 8'h5A, "R6 single read data", 32'(rq[0]), 32'h5A);
    chk(rq[1] == 8'hC3, "R7 ack carries flag value", 32'(rq[1]), 32'hC3);
  endtask

  task automatic t_read_burst8_wrap();
    rn = 0; flag_val = 8'h81;
    send_frame(mk_hdr(1, 0, 2'b11, 4'h5), 8'hFC, 0, 8'h00, 0);
    settle();
    chk(rn == 9, "R6 burst of eight reply length", 32'(rn), 9);
    for (int i = 0; i < 8; i++)
      chk(rq[i] == mem[8'(8'hFC + i)], "R6 burst read wraps modulo 256", 32'(rq[i]), 32'(mem[8'(8'hFC + i)]));
    chk(rq[8] == 8'h81, "R7 ack after burst data", 32'(rq[8]), 32'h81);
  endtask

  task automatic t_bad_crc();
    logic [7:0] keep;
    int w0;
    keep = mem[8'h60]; w0 = wd_cnt; rn = 0;
    wd[0] = 8'hEE;
    send_frame(mk_hdr(0, 0, 2'b00, 4'h5), 8'h60, 1, 8'h01, 0);
    chk(wdog_clr == 0 && reg_wr_en == 0, "R4 no action on bad crc",
        32'({wdog_clr, reg_wr_en}), 0);
    settle();
    chk(mem[8'h60] == keep, "R4 bad crc leaves register", 32'(mem[8'h60]), 32'(keep));
    chk(rn == 0 && wd_cnt == w0, "R4 bad crc silent", 32'(rn + wd_cnt - w0), 0);
  endtask

  task automatic t_sync_in_crc();
    logic [7:0] keep;
    keep = mem[8'h61]; rn = 0;
    wd[0] = 8'h12;
    send_frame(mk_hdr(0, 0, 2'b00, 4'h5), 8'h61, 1, 8'h00, 1);
    settle();
    chk(mem[8'h61] == keep && rn == 0, "R3 sync byte outside crc",
        32'({mem[8'h61], rn[7:0]}), 32'({keep, 8'd0}));
  endtask

  task automatic t_other_dev();
    logic [7:0] keep;
    int w0;
    keep = mem[8'h62]; w0 = wd_cnt; rn = 0;
    wd[0] = 8'h34;
    send_frame(mk_hdr(0, 0, 2'b00, 4'h9), 8'h62, 1, 8'h00, 0);
    settle();
    chk(mem[8'h62] == keep, "R4 R2 other device untouched", 32'(mem[8'h62]), 32'(keep));
    chk(rn == 0 && wd_cnt == w0, "R4 other device silent", 32'(rn + wd_cnt - w0), 0);
  endtask

  task automatic t_broadcast();
    int w0;
    w0 = wd_cnt; rn = 0;
    wd[0] = 8'h71; wd[1] = 8'h72;
    send_frame(mk_hdr(0, 1, 2'b01, 4'hA), 8'h70, 2, 8'h00, 0);
    settle();
    chk(mem[8'h70] == 8'h71 && mem[8'h71] == 8'h72, "R8 broadcast applied",
        32'({mem[8'h70], mem[8'h71]}), 32'h7172);
    chk(rn == 0, "R8 broadcast no reply", 32'(rn), 0);
    chk(wd_cnt == w0 + 1, "R9 broadcast clears watchdog", 32'(wd_cnt - w0), 1);
  endtask

  task automatic t_abort_mid();
    logic [7:0] keep, c;
    keep = mem[8'h50]; rn = 0;
    c = tb_crc(tb_crc(tb_crc(8'hFF, 8'h05), 8'h50), 8'h77);
    send_byte(8'h55, 1);
    send_byte(8'h05, 0);
    send_byte(8'h50, 0);
    @(negedge clk); frame_abort = 1;
    @(negedge clk); frame_abort = 0;
    send_byte(8'h77, 0);
    send_byte(c, 0);
    settle();
    chk(mem[8'h50] == keep && rn == 0, "R10 R1 aborted frame dropped",
        32'({mem[8'h50], rn[7:0]}), 32'({keep, 8'd0}));
  endtask

  task automatic t_backpressure();
    logic [7:0] h;
    rn = 0; tx_ready = 0; flag_val = 8'h44;
    send_frame(mk_hdr(1, 0, 2'b00, 4'h5), 8'h31, 0, 8'h00, 0);
    settle();
    h = tx_byte;
    chk(tx_valid == 1 && h == mem[8'h31], "R11 head byte presented",
        32'({tx_valid, h}), 32'({1'b1, mem[8'h31]}));
    repeat (3) @(negedge clk);
    chk(tx_byte == h && tx_valid == 1, "R11 held while stalled", 32'(tx_byte), 32'(h));
    tx_ready = 1;
    settle();
    chk(rn == 2 && rq[0] == mem[8'h31] && rq[1] == 8'h44, "R11 order kept after stall",
        32'({rn[7:0], rq[0], rq[1]}), 32'({8'd2, mem[8'h31], 8'h44}));
  endtask

  task automatic t_abort_flush();
    rn = 0; tx_ready = 0;
    send_frame(mk_hdr(1, 0, 2'b01, 4'h5), 8'h30, 0, 8'h00, 0);
    settle();
    @(negedge clk); frame_abort = 1;
    @(negedge clk); frame_abort = 0;
    chk(tx_valid == 0, "R10 abort empties reply queue", 32'(tx_valid), 0);
    tx_ready = 1;
    settle();
    chk(rn == 0, "R10 flushed bytes not sent", 32'(rn), 0);
  endtask

  task automatic t_restart();
    logic [7:0] keep;
    keep = mem[8'h40]; rn = 0;
    send_byte(8'h55, 1);
    send_byte(mk_hdr(0, 0, 2'b00, 4'h5), 0);
    send_byte(8'h40, 0);
    wd[0] = 8'h99;
    send_frame(mk_hdr(0, 0, 2'b00, 4'h5), 8'h41, 1, 8'h00, 0);
    settle();
    chk(mem[8'h40] == keep, "R12 partial frame discarded", 32'(mem[8'h40]), 32'(keep));
    chk(mem[8'h41] == 8'h99 && rn == 1, "R12 restarted frame applied",
        32'({mem[8'h41], rn[7:0]}), 32'({8'h99, 8'd1}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_single_write();
    t_burst_write4();
    t_read_single();
    t_read_burst8_wrap();
    t_bad_crc();
    t_sync_in_crc();
    t_other_dev();
    t_broadcast();
    t_abort_mid();
    t_backpressure();
    t_abort_flush();
    t_restart();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule